// File: doc/BRIEF.md
# Watchdog Input Conditioner

This block sits between three raw pins and a window watchdog's state machine. It takes a trigger pin and a mode pin that rest high, and a wake-up pin that rests low. Each pin goes through a synchroniser and then a debounce counter, so that the state machine sees only clean levels and strobes in the core clock domain.

The trigger and mode inputs use a short debounce. The wake-up input uses a much longer one. The block drives out the clean trigger and mode levels. It also produces three one-cycle strobes:
- an accept strobe on each rising edge of the clean trigger;
- an error strobe when the clean trigger stays low for too long;
- a wake strobe on every change of the clean wake-up level, rising or falling.

Reset is synchronous. It loads the rest values into the clean levels, so leaving reset never produces a strobe.

Top module: `wd_input_cond`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `trg_lvl` and `mode_lvl` read 1, and `trg_accept`, `trg_err` and `wake_edge` read 0, whatever the pins do.
- R2: A trigger pin change that is held steady reaches `trg_lvl` exactly SYNC_STAGES+TRG_DEB clock edges after it is first sampled. With the defaults 2 and 3 this is 5 edges.
- R3: A trigger pin pulse that lasts fewer than TRG_DEB (3) cycles is ignored. One of exactly TRG_DEB cycles is passed through. Any return to the current clean level restarts the count.
- R4: The mode pin is debounced like the trigger, with the same latency, and independently of it. A mode glitch of 2 cycles is ignored, and mode activity never raises `trg_accept`.
- R5: A wake-up pin pulse shorter than WUP_DEB (112) cycles produces no `wake_edge`. A change held for WUP_DEB cycles is accepted, and `wake_edge` rises 2+WUP_DEB (114) edges after the change is first sampled.
- R6: `wake_edge` is a one-cycle strobe for each change of the clean wake-up level, both rising and falling. An accepted high pulse therefore gives exactly 2 strobes.
- R7: `trg_accept` is a one-cycle strobe in the same cycle that `trg_lvl` goes from 0 to 1. A falling edge of `trg_lvl` gives no strobe.
- R8: `trg_err` pulses for one cycle once `trg_lvl` has been sampled low on TRG_LOW_MAX+1 (46) consecutive edges. A low period of 45 cycles gives no error. However long the low period lasts, it gives at most one error.
- R9: The low-time count clears whenever `trg_lvl` is high. Two low periods of 40 cycles, separated by a high period, give no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| trg_pin | input | 1 | Raw trigger pin, rests high |
| mode_pin | input | 1 | Raw mode pin, rests high |
| wake_pin | input | 1 | Raw wake-up pin, rests low |
| trg_lvl | output | 1 | Clean trigger level |
| mode_lvl | output | 1 | Clean mode level |
| trg_accept | output | 1 | One-cycle strobe on a rising clean trigger |
| trg_err | output | 1 | One-cycle strobe when the trigger low time is too long |
| wake_edge | output | 1 | One-cycle strobe on either clean wake-up edge |

## Verification
Trigger pulses of 2 and 3 cycles separate rejection from acceptance at the debounce boundary. A single held change pins down the exact latency, which catches an off-by-one in the synchroniser or in the counter. Low periods of 45, 46 and 120 cycles separate "no error", "error" and "only one error". Two 40-cycle lows in a row show whether the low-time count is cleared between them. Wake-up pulses of 111 and 112 cycles and a long pulse check the long debounce limit and the two-edge strobe, and mode glitches and steps check that the mode channel is independent.

// File: rtl/wd_input_cond.sv
`timescale 1ns/1ps
module wd_input_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int TRG_DEB     = 3,
  parameter int WUP_DEB     = 112,
  parameter int TRG_LOW_MAX = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic trg_pin,
  input  logic mode_pin,
  input  logic wake_pin,
  output logic trg_lvl,
  output logic mode_lvl,
  output logic trg_accept,
  output logic trg_err,
  output logic wake_edge
);
  localparam int CW = $clog2((WUP_DEB > TRG_DEB ? WUP_DEB : TRG_DEB) + 1);
  localparam int LW = $clog2(TRG_LOW_MAX + 2);

  logic [2:0] pins, lvl;
  logic       trg_chg, wake_chg, wake_lvl;
  logic [LW-1:0] low_cnt;

  assign pins = {wake_pin, mode_pin, trg_pin};

  for (genvar i = 0; i < 3; i++) begin : g_ch
    localparam int   DEB  = (i == 2) ? WUP_DEB : TRG_DEB;
    localparam logic IDLE = (i == 2) ? 1'b0 : 1'b1;
    logic [SYNC_STAGES-1:0] sh;
    logic [CW-1:0]          cnt;
    logic                   lvl_q, upd;

    assign upd    = (sh[SYNC_STAGES-1] != lvl_q) && (cnt == CW'(DEB - 1));
    assign lvl[i] = lvl_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sh    <= {SYNC_STAGES{IDLE}};
        cnt   <= '0;
        lvl_q <= IDLE;
      end else begin
        sh <= {sh[SYNC_STAGES-2:0], pins[i]};
        if (sh[SYNC_STAGES-1] == lvl_q) cnt <= '0;
        else if (upd) begin
          lvl_q <= sh[SYNC_STAGES-1];
          cnt   <= '0;
        end else cnt <= cnt + 1'b1;
      end
    end

    if (i != 1) begin : g_strobe
      logic s;
      always_ff @(posedge clk) begin
        if (rst) s <= 1'b0;
        else     s <= upd;
      end
      if (i == 0) begin : g_t
        assign trg_chg = s;
      end else begin : g_w
        assign wake_chg = s;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
      trg_err <= 1'b0;
    end else begin
      trg_err <= !lvl[0] && (low_cnt == LW'(TRG_LOW_MAX));
      if (lvl[0]) low_cnt <= '0;
      else if (low_cnt != LW'(TRG_LOW_MAX + 1)) low_cnt <= low_cnt + 1'b1;
    end
  end

  assign trg_lvl    = lvl[0];
  assign mode_lvl   = lvl[1];
  assign wake_lvl   = lvl[2];
  assign trg_accept = trg_chg & lvl[0];
  assign wake_edge  = wake_chg;
endmodule

// File: rtl/wd_input_cond_chk.sv
`timescale 1ns/1ps
module wd_input_cond_chk (
  input logic clk,
  input logic rst,
  input logic trg_lvl,
  input logic mode_lvl,
  input logic wake_lvl,
  input logic trg_accept,
  input logic trg_err,
  input logic wake_edge
);
  p_accept_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    trg_accept |=> !trg_accept);
  p_accept_on_rise_r7: assert property (@(posedge clk) disable iff (rst)
    trg_accept |-> (trg_lvl && !$past(trg_lvl)));
  p_rise_has_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (trg_lvl && !$past(trg_lvl)) |-> trg_accept);
  p_wake_on_change_r6: assert property (@(posedge clk) disable iff (rst)
    wake_edge |-> (wake_lvl != $past(wake_lvl)));
  p_wake_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    wake_edge |=> !wake_edge);
  p_err_when_low_r8: assert property (@(posedge clk) disable iff (rst)
    trg_err |-> !$past(trg_lvl));
  p_err_once_r8: assert property (@(posedge clk) disable iff (rst)
    trg_err |=> !trg_err);
  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (trg_lvl && mode_lvl && !trg_accept && !trg_err && !wake_edge));
endmodule

bind wd_input_cond wd_input_cond_chk u_chk (
  .clk(clk), .rst(rst), .trg_lvl(trg_lvl), .mode_lvl(mode_lvl),
  .wake_lvl(wake_lvl), .trg_accept(trg_accept), .trg_err(trg_err),
  .wake_edge(wake_edge)
);

// File: tb/test_wd_input_cond.sv
`timescale 1ns/1ps
module test_wd_input_cond;
  logic clk = 1'b0, rst = 1'b1;
  logic trg_pin = 1'b1, mode_pin = 1'b1, wake_pin = 1'b0;
  logic trg_lvl, mode_lvl, trg_accept, trg_err, wake_edge;
  int n_vec = 0, n_bad = 0;
  int n_acc = 0, n_err = 0, n_wk = 0;

  always #4 clk = ~clk;

  wd_input_cond i_wd_input_cond (
    .clk(clk), .rst(rst), .trg_pin(trg_pin), .mode_pin(mode_pin),
    .wake_pin(wake_pin), .trg_lvl(trg_lvl), .mode_lvl(mode_lvl),
    .trg_accept(trg_accept), .trg_err(trg_err), .wake_edge(wake_edge)
  );

  always @(negedge clk) if (!rst) begin
    n_acc += int'(trg_accept);
    n_err += int'(trg_err);
    n_wk  += int'(wake_edge);
  end

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear();
    n_acc = 0; n_err = 0; n_wk = 0;
  endtask

  task automatic t_reset();
    trg_pin = 1'b0; mode_pin = 1'b0; wake_pin = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 trg_lvl in reset", int'(trg_lvl), 1);
    chk("R1 mode_lvl in reset", int'(mode_lvl), 1);
    chk("R1 strobes in reset", int'(trg_accept | trg_err | wake_edge), 0);
    trg_pin = 1'b1; mode_pin = 1'b1; wake_pin = 1'b0;
    rst = 1'b0;
    clear();
    @(negedge clk);
    chk("R1 first cycle levels", int'(trg_lvl & mode_lvl), 1);
    repeat (20) @(negedge clk);
    chk("R1 no strobes after reset", n_acc + n_err + n_wk, 0);
  endtask

  task automatic t_latency();
    clear();
    trg_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 trg_lvl before 5 edges", int'(trg_lvl), 1);
    @(negedge clk);
    chk("R2 trg_lvl after 5 edges", int'(trg_lvl), 0);
    chk("R7 no accept on fall", int'(trg_accept), 0);
    repeat (5) @(negedge clk);
    trg_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk("R2 trg_lvl rise before 5 edges", int'(trg_lvl), 0);
    @(negedge clk);
    chk("R2 trg_lvl rise after 5 edges", int'(trg_lvl), 1);
    chk("R7 accept with rise", int'(trg_accept), 1);
    @(negedge clk);
    chk("R7 accept one cycle", int'(trg_accept), 0);
    repeat (10) @(negedge clk);
    chk("R7 accept count", n_acc, 1);
  endtask

  task automatic t_glitch(input int w, input int exp_acc);
    clear();
    trg_pin = 1'b0;
    repeat (w) @(negedge clk);
    trg_pin = 1'b1;
    repeat (20) @(negedge clk);
    chk($sformatf("R3 trigger pulse of %0d", w), n_acc, exp_acc);
  endtask

  task automatic t_low(input int len, input int exp_err, input string req);
    clear();
    trg_pin = 1'b0;
    repeat (len) @(negedge clk);
    trg_pin = 1'b1;
    repeat (20) @(negedge clk);
    chk($sformatf("%s low of %0d errors", req, len), n_err, exp_err);
    chk($sformatf("%s low of %0d accepts", req, len), n_acc, 1);
  endtask

  task automatic t_two_lows();
    clear();
    trg_pin = 1'b0; repeat (40) @(negedge clk);
    trg_pin = 1'b1; repeat (10) @(negedge clk);
    trg_pin = 1'b0; repeat (40) @(negedge clk);
    trg_pin = 1'b1; repeat (20) @(negedge clk);
    chk("R9 two lows of 40 no error", n_err, 0);
  endtask

  task automatic t_mode();
    clear();
    mode_pin = 1'b0; repeat (2) @(negedge clk);
    mode_pin = 1'b1; repeat (10) @(negedge clk);
    chk("R4 mode glitch ignored", int'(mode_lvl), 1);
    mode_pin = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 mode before 5 edges", int'(mode_lvl), 1);
    @(negedge clk);
    chk("R4 mode after 5 edges", int'(mode_lvl), 0);
    chk("R4 trigger untouched", int'(trg_lvl), 1);
    mode_pin = 1'b1; repeat (10) @(negedge clk);
    chk("R4 mode back high", int'(mode_lvl), 1);
    chk("R4 no accept from mode", n_acc, 0);
  endtask

  task automatic t_wake_pulse(input int len, input int exp_wk, input string req);
    clear();
    wake_pin = 1'b1;
    repeat (len) @(negedge clk);
    wake_pin = 1'b0;
    repeat (200) @(negedge clk);
    chk($sformatf("%s wake pulse of %0d", req, len), n_wk, exp_wk);
  endtask

  task automatic t_wake_latency();
    clear();
    wake_pin = 1'b1;
    repeat (113) @(negedge clk);
    chk("R5 wake_edge before 114 edges", int'(wake_edge), 0);
    @(negedge clk);
    chk("R5 wake_edge at 114 edges", int'(wake_edge), 1);
    @(negedge clk);
    chk("R6 wake_edge one cycle", int'(wake_edge), 0);
    wake_pin = 1'b0;
    repeat (200) @(negedge clk);
    chk("R6 wake edges both ways", n_wk, 2);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_glitch(2, 0);
    t_glitch(3, 1);
    t_low(45, 0, "R8");
    t_low(46, 1, "R8");
    t_low(120, 1, "R8");
    t_two_lows();
    t_mode();
    t_wake_pulse(111, 0, "R5");
    t_wake_pulse(112, 2, "R5");
    t_wake_pulse(300, 2, "R6");
    t_wake_latency();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule